// File: doc/BRIEF.md
# Multi-thread instruction line fetch controller

This block sits at the front of an instruction pipeline that runs several hardware threads. Each thread has a program counter and a one-line buffer that holds a 64-byte instruction line. In each cycle an outside selector names one thread. If that thread's line is already buffered, the block hands up to a configurable number of consecutive 32-bit instructions to decode. If the line is not buffered, the block sends a line request to the instruction cache. The cache accepts or rejects each request in the same cycle. It later returns the line with the thread number and the request tag attached.

A rejected request is parked in one retry slot shared by all threads. While that slot is occupied, the cache counts as blocked and no thread may start a request or extract from its buffer. A retry grant from the cache resends the parked request. A squash redirects one thread to a new address. It abandons that thread's outstanding miss and frees the retry slot if the thread owns it. Responses that no longer match a waiting request are discarded and counted. A branch predictor outside the block marks extracted lanes as predicted taken and supplies the target.

Each thread runs its own state machine with these states:
- TS_RUN: may fetch.
- TS_WAIT_RETRY: its request is parked in the retry slot.
- TS_WAIT_RSP: a miss is outstanding.
- TS_ACC_DONE: the line has arrived.
- TS_BLOCKED: a downstream stall is active.
- TS_SQUASH: redirected this cycle.

Transitions:
- A squash moves any state to TS_SQUASH.
- TS_SQUASH goes to TS_RUN, or to TS_BLOCKED if stalled.
- TS_RUN goes to TS_BLOCKED on a stall. When it issues a request, it goes to TS_WAIT_RSP if the cache accepts and to TS_WAIT_RETRY if the cache rejects.
- TS_WAIT_RETRY goes to TS_WAIT_RSP when the resend is accepted.
- TS_WAIT_RSP goes to TS_ACC_DONE on a matching response, or to TS_BLOCKED if stalled at that moment.
- TS_ACC_DONE goes to TS_RUN when selected, or to TS_BLOCKED if stalled.
- TS_BLOCKED goes to TS_RUN once the stall is gone.

The retry slot has two states, RS_FREE and RS_HELD.

Top module: `ifetch_line_ctrl`

## Requirements
- R1: Every line request carries an address whose low 6 bits are zero: the thread PC with its byte-in-line bits cleared.
- R2: A selected thread in TS_RUN whose buffer is valid and whose buffered line address equals its aligned PC issues no request and extracts directly from the buffer.
- R3: No request is started and nothing is extracted while the cache is blocked, while switched_out is high, or while irq_pending is high with priv_mode low.
- R4: A rejected request (ic_req_valid high, ic_req_accept low) is held in the single retry slot, the thread waits, and the cache becomes blocked. A later ic_retry_grant resends the same address, thread and tag. Acceptance of the resend moves the thread to TS_WAIT_RSP and clears the block. A grant while the slot is empty issues no request.
- R5: A response is taken only if its thread is in TS_WAIT_RSP and its tag equals that thread's outstanding tag. Any other response is dropped, and drop_count rises by one on the next cycle.
- R6: A taken response fills the buffer and marks it valid. The thread enters TS_BLOCKED if its stall is high, and TS_ACC_DONE otherwise. TS_ACC_DONE becomes TS_RUN on its next selected cycle without extracting. TS_BLOCKED becomes TS_RUN on its first cycle without a stall, selected or not.
- R7: Extraction covers consecutive lanes starting at lane 0. It stops at the end of the line, at the lane count FETCH_W, or after the first lane whose pred_taken bit is set (that lane is included).
- R8: A squash loads the thread PC with sq_pc, drops the thread's outstanding miss, frees the retry slot if the thread owns it, and puts the thread in TS_SQUASH. No fetch happens for that thread in the following cycle.
- R9: Lane i has address (PC with bits 1:0 cleared) + 4*i. Its instruction is the line word at that address, word k occupying bits 32k+31:32k of the line.
- R10: After extraction the PC becomes pred_target if a taken lane ended the group. Otherwise it becomes the last lane's address plus 4.
- R11: During and right after reset no request or lane is valid, drop_count is zero, and every thread is in TS_RUN at RESET_PC with an empty buffer.
- R12: A selected thread whose stall is high neither extracts nor requests, and it moves to TS_BLOCKED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | A thread is selected this cycle |
| sel_tid | input | TID_W | Selected thread |
| stall_in | input | NUM_THR | Per-thread downstream stall |
| switched_out | input | 1 | Unit is switched out; no fetch |
| priv_mode | input | 1 | Privileged mode qualifier |
| irq_pending | input | 1 | Interrupt pending |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_pc | input | ADDR_W | New PC for the squashed thread |
| ic_req_valid | output | 1 | Line request to the cache |
| ic_req_addr | output | ADDR_W | Line-aligned request address |
| ic_req_tid | output | TID_W | Requesting thread |
| ic_req_tag | output | TAG_W | Request tag |
| ic_req_accept | input | 1 | Cache accepts the request this cycle |
| ic_retry_grant | input | 1 | Cache invites a resend |
| ic_rsp_valid | input | 1 | Line response |
| ic_rsp_tid | input | TID_W | Response thread |
| ic_rsp_tag | input | TAG_W | Response tag |
| ic_rsp_data | input | LINE_BITS | Line data |
| pred_taken | input | FETCH_W | Per-lane predicted-taken flag |
| pred_target | input | ADDR_W | Predicted target address |
| dec_valid | output | FETCH_W | Lane valid toward decode |
| dec_inst | output | FETCH_W*32 | Lane instructions |
| dec_pc | output | FETCH_W*ADDR_W | Lane addresses |
| drop_count | output | CNT_W | Count of discarded responses |

## Verification
The hardest situation to reach is a reject that lands in the retry slot and is then cleared by a squash of the owning thread before any grant arrives. This needs one thread parked in TS_WAIT_RETRY, another thread with a valid buffered line, and the squash timed between them. The stimulus first fills thread 0's line and moves it into TS_ACC_DONE. It then makes thread 1 miss with ic_req_accept low and squashes thread 1 on the next cycle. It follows with a stray retry grant while thread 0 extracts, which shows both that the block was released and that an empty slot causes no resend. Stale responses are produced in three separate ways: a wrong tag, a repeat after completion, and a reply to a squashed miss.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    typedef enum logic [2:0] {
        TS_RUN,
        TS_WAIT_RETRY,
        TS_WAIT_RSP,
        TS_ACC_DONE,
        TS_BLOCKED,
        TS_SQUASH
    } thread_st_e;

    typedef enum logic {
        RS_FREE,
        RS_HELD
    } slot_st_e;

    localparam int INST_BITS = 32;
    localparam int INST_BYTES = 4;

endpackage

// File: rtl/ifetch_retry_slot.sv
module ifetch_retry_slot
    import ifetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    parameter int TID_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reject,
    input  logic [TID_W-1:0]  rej_tid,
    input  logic [ADDR_W-1:0] rej_addr,
    input  logic [TAG_W-1:0]  rej_tag,
    input  logic              grant,
    input  logic              accept,
    input  logic              sq_valid,
    input  logic [TID_W-1:0]  sq_tid,
    output logic [TID_W-1:0]  slot_tid,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [TAG_W-1:0]  slot_tag,
    output logic              blocked,
    output logic              resend,
    output logic              resend_ok
);

    slot_st_e          st_q, st_d;
    logic              blocked_q, blocked_d;
    logic [TID_W-1:0]  tid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  tag_q;
    logic              sq_hits;

    assign sq_hits = sq_valid && (st_q == RS_HELD) && (sq_tid == tid_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_FREE: if (reject) st_d = RS_HELD;
            RS_HELD: if (resend_ok || sq_hits) st_d = RS_FREE;
            default: st_d = RS_FREE;
        endcase
    end

    always_comb begin
        blocked_d = blocked_q;
        if (reject)
            blocked_d = 1'b1;
        else if (resend_ok || sq_hits)
            blocked_d = 1'b0;
        else if (grant && (st_q == RS_FREE))
            blocked_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= RS_FREE;
            blocked_q <= 1'b0;
            tid_q     <= '0;
            addr_q    <= '0;
            tag_q     <= '0;
        end else begin
            st_q      <= st_d;
            blocked_q <= blocked_d;
            if (reject) begin
                tid_q  <= rej_tid;
                addr_q <= rej_addr;
                tag_q  <= rej_tag;
            end
        end
    end

    always_comb begin
        resend    = grant && (st_q == RS_HELD) && !sq_hits;
        resend_ok = resend && accept;
        slot_tid  = tid_q;
        slot_addr = addr_q;
        slot_tag  = tag_q;
        blocked   = blocked_q;
    end

    // R4
    reject_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (st_q == RS_FREE));
    // R4
    resend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resend_ok |=> (!blocked_q && (st_q == RS_FREE)));
    // R8
    squash_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_hits && !reject) |=> (st_q == RS_FREE));

endmodule

// File: rtl/ifetch_extract.sv
module ifetch_extract
    import ifetch_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int FETCH_W   = 4,
    parameter int LINE_BITS = 512
) (
    input  logic [ADDR_W-1:0]         pc,
    input  logic [LINE_BITS-1:0]      line,
    input  logic [FETCH_W-1:0]        pred_taken,
    input  logic [ADDR_W-1:0]         pred_target,
    output logic [FETCH_W-1:0]        lane_vld,
    output logic [FETCH_W*32-1:0]     lane_inst,
    output logic [FETCH_W*ADDR_W-1:0] lane_pc,
    output logic [ADDR_W-1:0]         next_pc
);

    localparam int LINE_WORDS = LINE_BITS / INST_BITS;
    localparam int WI_W       = $clog2(LINE_WORDS);

    logic [INST_BITS-1:0] words [LINE_WORDS];

    genvar g;
    generate
        for (g = 0; g < LINE_WORDS; g++) begin : g_unpack
            assign words[g] = line[g*INST_BITS +: INST_BITS];
        end
    endgenerate

    logic [ADDR_W-1:0] base;
    logic [WI_W:0]     wpos;
    logic              stop;
    logic              taken;
    logic [ADDR_W-1:0] last_pc;

    always_comb begin
        base      = pc & ~ADDR_W'(INST_BYTES - 1);
        stop      = 1'b0;
        taken     = 1'b0;
        last_pc   = base - ADDR_W'(INST_BYTES);
        lane_vld  = '0;
        lane_inst = '0;
        lane_pc   = '0;
        for (int i = 0; i < FETCH_W; i++) begin
            wpos = {1'b0, base[WI_W+1:2]} + (WI_W+1)'(i);
            lane_pc[i*ADDR_W +: ADDR_W] = base + ADDR_W'(INST_BYTES * i);
            if (!stop && (int'(wpos) < LINE_WORDS)) begin
                lane_vld[i] = 1'b1;
                lane_inst[i*32 +: 32] = words[wpos[WI_W-1:0]];
                last_pc = base + ADDR_W'(INST_BYTES * i);
                if (pred_taken[i]) begin
                    stop  = 1'b1;
                    taken = 1'b1;
                end
            end
        end
        next_pc = taken ? pred_target : last_pc + ADDR_W'(INST_BYTES);
    end

endmodule

// File: rtl/ifetch_thread_ctx.sv
module ifetch_thread_ctx
    import ifetch_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              TAG_W      = 4,
    parameter int              TID_W      = 1,
    parameter int              LINE_BYTES = 64,
    parameter int              ID         = 0,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stall,
    input  logic                    sel,
    input  logic                    issue_ok,
    input  logic                    squash,
    input  logic [ADDR_W-1:0]       squash_pc,
    input  logic                    rsp_valid,
    input  logic [TID_W-1:0]        rsp_tid,
    input  logic [TAG_W-1:0]        rsp_tag,
    input  logic [LINE_BYTES*8-1:0] rsp_data,
    input  logic                    new_accept,
    input  logic                    retry_done,
    input  logic [ADDR_W-1:0]       adv_pc,
    output logic [ADDR_W-1:0]       pc,
    output logic [LINE_BYTES*8-1:0] line,
    output logic                    want_req,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [TAG_W-1:0]        req_tag,
    output logic                    extract,
    output logic                    rsp_drop
);

    localparam int LINE_BITS = LINE_BYTES * 8;

    thread_st_e           st_q, st_d;
    logic [ADDR_W-1:0]    pc_q, buf_addr_q, aligned;
    logic                 buf_vld_q, hit, go, rsp_mine, take;
    logic [LINE_BITS-1:0] buf_q;
    logic [TAG_W-1:0]     tag_ctr_q, out_tag_q;

    always_comb begin
        aligned  = pc_q & ~ADDR_W'(LINE_BYTES - 1);
        hit      = buf_vld_q && (buf_addr_q == aligned);
        go       = (st_q == TS_RUN) && sel && !stall && !squash && issue_ok;
        rsp_mine = rsp_valid && (rsp_tid == TID_W'(ID));
        take     = rsp_mine && (st_q == TS_WAIT_RSP) && (rsp_tag == out_tag_q) && !squash;
    end

    always_comb begin
        st_d = st_q;
        if (squash) begin
            st_d = TS_SQUASH;
        end else begin
            unique case (st_q)
                TS_RUN: begin
                    if (stall)
                        st_d = TS_BLOCKED;
                    else if (go && !hit)
                        st_d = new_accept ? TS_WAIT_RSP : TS_WAIT_RETRY;
                end
                TS_WAIT_RETRY: if (retry_done) st_d = TS_WAIT_RSP;
                TS_WAIT_RSP:   if (take) st_d = stall ? TS_BLOCKED : TS_ACC_DONE;
                TS_ACC_DONE: begin
                    if (stall)
                        st_d = TS_BLOCKED;
                    else if (sel)
                        st_d = TS_RUN;
                end
                TS_BLOCKED, TS_SQUASH: st_d = stall ? TS_BLOCKED : TS_RUN;
                default: st_d = TS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= TS_RUN;
            pc_q       <= RESET_PC;
            buf_addr_q <= '0;
            buf_vld_q  <= 1'b0;
            buf_q      <= '0;
            tag_ctr_q  <= '0;
            out_tag_q  <= '0;
        end else begin
            st_q <= st_d;
            if (squash)
                pc_q <= squash_pc;
            else if (go && hit)
                pc_q <= adv_pc;
            if (go && !hit) begin
                buf_addr_q <= aligned;
                buf_vld_q  <= 1'b0;
                out_tag_q  <= tag_ctr_q;
                tag_ctr_q  <= tag_ctr_q + 1'b1;
            end else if (take) begin
                buf_q     <= rsp_data;
                buf_vld_q <= 1'b1;
            end
        end
    end

    always_comb begin
        pc       = pc_q;
        line     = buf_q;
        want_req = go && !hit;
        extract  = go && hit;
        req_addr = aligned;
        req_tag  = tag_ctr_q;
        rsp_drop = rsp_mine && !take;
    end

    // R8
    squash_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> ((st_q == TS_SQUASH) && (pc_q == $past(squash_pc))));
    // R5
    rsp_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == TS_WAIT_RSP) && !rsp_valid && !squash) |=> (st_q == TS_WAIT_RSP));
    // R6
    rsp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !stall) |=> ((st_q == TS_ACC_DONE) && buf_vld_q));
    // R12
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == TS_RUN) && stall && !squash) |=> (st_q == TS_BLOCKED));

endmodule

// File: rtl/ifetch_line_ctrl.sv
module ifetch_line_ctrl
    import ifetch_pkg::*;
#(
    parameter int                NUM_THR    = 2,
    parameter int                ADDR_W     = 32,
    parameter int                TAG_W      = 4,
    parameter int                FETCH_W    = 4,
    parameter int                LINE_BYTES = 64,
    parameter int                CNT_W      = 8,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0,
    localparam int               TID_W      = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
    localparam int               LINE_BITS  = LINE_BYTES * 8,
    localparam int               OFS_W      = $clog2(LINE_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_valid,
    input  logic [TID_W-1:0]          sel_tid,
    input  logic [NUM_THR-1:0]        stall_in,
    input  logic                      switched_out,
    input  logic                      priv_mode,
    input  logic                      irq_pending,
    input  logic                      sq_valid,
    input  logic [TID_W-1:0]          sq_tid,
    input  logic [ADDR_W-1:0]         sq_pc,
    output logic                      ic_req_valid,
    output logic [ADDR_W-1:0]         ic_req_addr,
    output logic [TID_W-1:0]          ic_req_tid,
    output logic [TAG_W-1:0]          ic_req_tag,
    input  logic                      ic_req_accept,
    input  logic                      ic_retry_grant,
    input  logic                      ic_rsp_valid,
    input  logic [TID_W-1:0]          ic_rsp_tid,
    input  logic [TAG_W-1:0]          ic_rsp_tag,
    input  logic [LINE_BITS-1:0]      ic_rsp_data,
    input  logic [FETCH_W-1:0]        pred_taken,
    input  logic [ADDR_W-1:0]         pred_target,
    output logic [FETCH_W-1:0]        dec_valid,
    output logic [FETCH_W*32-1:0]     dec_inst,
    output logic [FETCH_W*ADDR_W-1:0] dec_pc,
    output logic [CNT_W-1:0]          drop_count
);

    logic [ADDR_W-1:0]    pc_a       [NUM_THR];
    logic [LINE_BITS-1:0] line_a     [NUM_THR];
    logic [ADDR_W-1:0]    req_addr_a [NUM_THR];
    logic [TAG_W-1:0]     req_tag_a  [NUM_THR];
    logic [NUM_THR-1:0]   want_a, ext_a, drop_a;

    logic              blocked, resend, resend_ok, issue_ok, new_req, reject;
    logic [TID_W-1:0]  slot_tid;
    logic [ADDR_W-1:0] slot_addr, ex_next_pc;
    logic [TAG_W-1:0]  slot_tag;
    logic [FETCH_W-1:0]        lane_vld;
    logic [FETCH_W*32-1:0]     lane_inst;
    logic [FETCH_W*ADDR_W-1:0] lane_pc;
    logic [CNT_W-1:0]  drop_q;

    assign issue_ok = !blocked && !switched_out && !(irq_pending && !priv_mode);
    assign new_req  = |want_a;
    assign reject   = new_req && !ic_req_accept;

    genvar g;
    generate
        for (g = 0; g < NUM_THR; g++) begin : g_thr
            ifetch_thread_ctx #(
                .ADDR_W(ADDR_W), .TAG_W(TAG_W), .TID_W(TID_W),
                .LINE_BYTES(LINE_BYTES), .ID(g), .RESET_PC(RESET_PC)
            ) i_ctx (
                .clk        (clk),
                .rst_n      (rst_n),
                .stall      (stall_in[g]),
                .sel        (sel_valid && (sel_tid == TID_W'(g))),
                .issue_ok   (issue_ok),
                .squash     (sq_valid && (sq_tid == TID_W'(g))),
                .squash_pc  (sq_pc),
                .rsp_valid  (ic_rsp_valid),
                .rsp_tid    (ic_rsp_tid),
                .rsp_tag    (ic_rsp_tag),
                .rsp_data   (ic_rsp_data),
                .new_accept (ic_req_accept),
                .retry_done (resend_ok && (slot_tid == TID_W'(g))),
                .adv_pc     (ex_next_pc),
                .pc         (pc_a[g]),
                .line       (line_a[g]),
                .want_req   (want_a[g]),
                .req_addr   (req_addr_a[g]),
                .req_tag    (req_tag_a[g]),
                .extract    (ext_a[g]),
                .rsp_drop   (drop_a[g])
            );
        end
    endgenerate

    ifetch_retry_slot #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .TID_W(TID_W)) i_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .reject    (reject),
        .rej_tid   (sel_tid),
        .rej_addr  (req_addr_a[sel_tid]),
        .rej_tag   (req_tag_a[sel_tid]),
        .grant     (ic_retry_grant),
        .accept    (ic_req_accept),
        .sq_valid  (sq_valid),
        .sq_tid    (sq_tid),
        .slot_tid  (slot_tid),
        .slot_addr (slot_addr),
        .slot_tag  (slot_tag),
        .blocked   (blocked),
        .resend    (resend),
        .resend_ok (resend_ok)
    );

    ifetch_extract #(.ADDR_W(ADDR_W), .FETCH_W(FETCH_W), .LINE_BITS(LINE_BITS)) i_ext (
        .pc          (pc_a[sel_tid]),
        .line        (line_a[sel_tid]),
        .pred_taken  (pred_taken),
        .pred_target (pred_target),
        .lane_vld    (lane_vld),
        .lane_inst   (lane_inst),
        .lane_pc     (lane_pc),
        .next_pc     (ex_next_pc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_q <= '0;
        else if (|drop_a)
            drop_q <= drop_q + 1'b1;
    end

    always_comb begin
        if (resend) begin
            ic_req_valid = 1'b1;
            ic_req_addr  = slot_addr;
            ic_req_tid   = slot_tid;
            ic_req_tag   = slot_tag;
        end else begin
            ic_req_valid = new_req;
            ic_req_addr  = req_addr_a[sel_tid];
            ic_req_tid   = sel_tid;
            ic_req_tag   = req_tag_a[sel_tid];
        end
        dec_valid  = (|ext_a) ? lane_vld : '0;
        dec_inst   = lane_inst;
        dec_pc     = lane_pc;
        drop_count = drop_q;
    end

    // R1
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ic_req_valid |-> (ic_req_addr[OFS_W-1:0] == '0));
    // R3
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (switched_out || (irq_pending && !priv_mode)) |-> ((dec_valid == '0) && !new_req));

    generate
        for (g = 1; g < FETCH_W; g++) begin : g_lane_chk
            // R7
            lane_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dec_valid[g] |-> dec_valid[g-1]);
        end
    endgenerate

endmodule

// File: tb/test_ifetch_line_ctrl.sv
`timescale 1ns/1ps
module test_ifetch_line_ctrl;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sel_valid;
    logic [0:0]   sel_tid;
    logic [1:0]   stall_in;
    logic         switched_out, priv_mode, irq_pending;
    logic         sq_valid;
    logic [0:0]   sq_tid;
    logic [31:0]  sq_pc;
    logic         ic_req_valid;
    logic [31:0]  ic_req_addr;
    logic [0:0]   ic_req_tid;
    logic [3:0]   ic_req_tag;
    logic         ic_req_accept, ic_retry_grant, ic_rsp_valid;
    logic [0:0]   ic_rsp_tid;
    logic [3:0]   ic_rsp_tag;
    logic [511:0] ic_rsp_data;
    logic [3:0]   pred_taken;
    logic [31:0]  pred_target;
    logic [3:0]   dec_valid;
    logic [127:0] dec_inst;
    logic [127:0] dec_pc;
    logic [7:0]   drop_count;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [3:0] tag_a, tag_b, tag_c, tag_r;

    always #2.5 clk = ~clk;

    ifetch_line_ctrl i_ifetch_line_ctrl (
        .clk, .rst_n, .sel_valid, .sel_tid, .stall_in, .switched_out, .priv_mode,
        .irq_pending, .sq_valid, .sq_tid, .sq_pc, .ic_req_valid, .ic_req_addr,
        .ic_req_tid, .ic_req_tag, .ic_req_accept, .ic_retry_grant, .ic_rsp_valid,
        .ic_rsp_tid, .ic_rsp_tag, .ic_rsp_data, .pred_taken, .pred_target,
        .dec_valid, .dec_inst, .dec_pc, .drop_count
    );

    typedef struct packed {
        logic [3:0]  pred;
        logic [31:0] tgt;
        logic [3:0]  mask;
        logic [31:0] first;
    } vec_t;

    // extraction walk over the buffered line at 0x1000 (R7, R9, R10, R2)
    localparam vec_t VECS [6] = '{
        '{4'b0000, 32'h0000_0000, 4'b1111, 32'h0000_1008},
        '{4'b0010, 32'h0000_1030, 4'b0011, 32'h0000_1018},
        '{4'b0001, 32'h0000_1004, 4'b0001, 32'h0000_1030},
        '{4'b0000, 32'h0000_0000, 4'b1111, 32'h0000_1004},
        '{4'b1000, 32'h0000_1038, 4'b1111, 32'h0000_1014},
        '{4'b0000, 32'h0000_0000, 4'b0011, 32'h0000_1038}
    };

    function automatic logic [511:0] mkline(input logic [31:0] base);
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = 32'hA500_0000 ^ (base + 32'(4*w));
        return l;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_lanes(input string req, input logic [3:0] mask,
                               input logic [31:0] first);
        check(req, "lane mask", 64'(dec_valid), 64'(mask));
        for (int i = 0; i < 4; i++) begin
            if (mask[i]) begin
                automatic logic [31:0] p = first + 32'(4*i);
                check(req, "lane pc", 64'(dec_pc[i*32 +: 32]), 64'(p));
                check(req, "lane inst", 64'(dec_inst[i*32 +: 32]), 64'(32'hA500_0000 ^ p));
            end
        end
    endtask

    task automatic clear_in();
        sel_valid = 0; sel_tid = 0; stall_in = 0; switched_out = 0; priv_mode = 0;
        irq_pending = 0; sq_valid = 0; sq_tid = 0; sq_pc = 0; ic_req_accept = 0;
        ic_retry_grant = 0; ic_rsp_valid = 0; ic_rsp_tid = 0; ic_rsp_tag = 0;
        ic_rsp_data = '0; pred_taken = 0; pred_target = 0;
    endtask

    task automatic next();
        @(negedge clk);
        clear_in();
    endtask

    task automatic pick(input logic [0:0] t);
        sel_valid = 1; sel_tid = t;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        check("R11", "req valid in reset", 64'(ic_req_valid), 0);
        check("R11", "lanes in reset", 64'(dec_valid), 0);
        check("R11", "drop count", 64'(drop_count), 0);
        @(negedge clk);
        rst_n = 1;

        // thread 0 redirect
        sq_valid = 1; sq_tid = 0; sq_pc = 32'h1008; #1;
        check("R11", "idle after reset", 64'(ic_req_valid), 0);
        next();
        pick(0); #1;
        check("R8", "no request while squashing", 64'(ic_req_valid), 0);
        check("R8", "no lanes while squashing", 64'(dec_valid), 0);
        next();
        pick(0); ic_req_accept = 1; #1;
        check("R1", "miss request", 64'(ic_req_valid), 1);
        check("R1", "aligned addr", 64'(ic_req_addr), 64'h1000);
        check("R1", "req tid", 64'(ic_req_tid), 0);
        tag_a = ic_req_tag;
        next();
        ic_rsp_valid = 1; ic_rsp_tid = 0; ic_rsp_tag = tag_a; ic_rsp_data = mkline(32'h1000);
        next();
        pick(0); #1;
        check("R6", "no lanes in access-complete", 64'(dec_valid), 0);
        next();

        for (int v = 0; v < 6; v++) begin
            pick(0); pred_taken = VECS[v].pred; pred_target = VECS[v].tgt; #1;
            check_lanes("R7", VECS[v].mask, VECS[v].first);
            check("R2", "buffer reuse without request", 64'(ic_req_valid), 0);
            next();
        end

        // end of line reached -> miss on next line, rejected
        pick(0); #1;
        check("R10", "sequential next line", 64'(ic_req_addr), 64'h1040);
        check("R4", "request presented", 64'(ic_req_valid), 1);
        tag_r = ic_req_tag;
        next();
        pick(1); #1;
        check("R3", "blocked cache stops other thread", 64'(ic_req_valid), 0);
        next();
        ic_retry_grant = 1; ic_req_accept = 1; #1;
        check("R4", "resend valid", 64'(ic_req_valid), 1);
        check("R4", "resend addr", 64'(ic_req_addr), 64'h1040);
        check("R4", "resend tid", 64'(ic_req_tid), 0);
        check("R4", "resend tag", 64'(ic_req_tag), 64'(tag_r));
        next();
        pick(1); ic_req_accept = 1; #1;
        check("R4", "block cleared after resend", 64'(ic_req_valid), 1);
        check("R1", "thread 1 addr", 64'(ic_req_addr), 64'h0);
        check("R1", "thread 1 tid", 64'(ic_req_tid), 1);
        tag_b = ic_req_tag;
        next();
        ic_rsp_valid = 1; ic_rsp_tid = 0; ic_rsp_tag = tag_r + 4'd1; ic_rsp_data = '1;
        next();
        #1;
        check("R5", "wrong tag dropped", 64'(drop_count), 1);
        ic_rsp_valid = 1; ic_rsp_tid = 0; ic_rsp_tag = tag_r; ic_rsp_data = mkline(32'h1040);
        next();
        ic_rsp_valid = 1; ic_rsp_tid = 0; ic_rsp_tag = tag_r; ic_rsp_data = '1;
        next();
        #1;
        check("R5", "repeat response dropped", 64'(drop_count), 2);
        sq_valid = 1; sq_tid = 1; sq_pc = 32'h2000;
        next();
        ic_rsp_valid = 1; ic_rsp_tid = 1; ic_rsp_tag = tag_b; ic_rsp_data = '1;
        next();
        #1;
        check("R8", "squashed miss response dropped", 64'(drop_count), 3);
        pick(1); #1;
        check("R4", "thread 1 request to reject", 64'(ic_req_valid), 1);
        check("R8", "redirected addr", 64'(ic_req_addr), 64'h2000);
        next();
        sq_valid = 1; sq_tid = 1; sq_pc = 32'h2000; pick(0); #1;
        check("R6", "access-complete to run, no lanes", 64'(dec_valid), 0);
        next();
        ic_retry_grant = 1; pick(0); #1;
        check("R4", "grant with empty slot sends nothing", 64'(ic_req_valid), 0);
        check_lanes("R8", 4'b1111, 32'h1040);
        next();
        irq_pending = 1; pick(0); #1;
        check("R3", "interrupt blocks lanes", 64'(dec_valid), 0);
        check("R3", "interrupt blocks request", 64'(ic_req_valid), 0);
        next();
        irq_pending = 1; priv_mode = 1; pick(0); #1;
        check_lanes("R3", 4'b1111, 32'h1050);
        next();
        switched_out = 1; pick(0); #1;
        check("R3", "switched out blocks lanes", 64'(dec_valid), 0);
        next();
        sq_valid = 1; sq_tid = 0; sq_pc = 32'h1047;
        next();
        pick(0); #1;
        check("R8", "no lanes in squash cycle", 64'(dec_valid), 0);
        next();
        pick(0); #1;
        check_lanes("R9", 4'b1111, 32'h1044);
        next();
        stall_in = 2'b01; pick(0); #1;
        check("R12", "stall blocks lanes", 64'(dec_valid), 0);
        check("R12", "stall blocks request", 64'(ic_req_valid), 0);
        next();
        next();
        pick(0); #1;
        check_lanes("R12", 4'b1111, 32'h1054);
        next();
        pick(1); ic_req_accept = 1; #1;
        check("R1", "thread 1 line request", 64'(ic_req_addr), 64'h2000);
        tag_c = ic_req_tag;
        next();
        stall_in = 2'b10; ic_rsp_valid = 1; ic_rsp_tid = 1; ic_rsp_tag = tag_c;
        ic_rsp_data = mkline(32'h2000);
        next();
        next();
        pick(1); #1;
        check_lanes("R6", 4'b1111, 32'h2000);
        check("R5", "taken responses not counted", 64'(drop_count), 3);
        next();

        done = 1;
        summary();
        $finish;
    end

endmodule